// File: doc/BRIEF.md
# Serial Character Transmitter with Clear-to-Send Gating

This block turns bytes into asynchronous serial characters on a line that rests high. A character is a low start bit, the data bits least significant first, an optional ninth bit for multiprocessor addressing, and one or two high stop bits. Bit boundaries come from an external baud tick, so every bit spans exactly one tick period. A byte is offered on a valid/ready handshake and is captured, together with its ninth-bit value and the frame options, when the engine is idle.

Flow control comes from an active-low clear-to-send pin. When checking is switched on, the pin is taken through a two-flop synchronizer and consulted only in the cycle just before a character would begin. If the far end is not ready, the character waits. A character that has begun always runs to the end of its last stop bit, whatever the pin does meanwhile.

Top module: `uart_tx_cts`

## Requirements
- R1: After reset, and whenever no character is pending or in flight, `tx_line` is 1, `tx_busy` is 0 and `tx_ready` is 1.
- R2: A character is sent as one start bit of value 0, then data bits 0 through 7 with bit 0 first, then the stop bits of value 1.
- R3: With `mp_mode_en` captured as 1, one extra bit follows data bit 7 and comes before the first stop bit, carrying the captured `mp_bit_in`. With it captured as 0, no extra bit is sent.
- R4: `two_stop_sel` captured as 0 gives one stop bit, and captured as 1 gives two.
- R5: Every bit lasts exactly one baud tick period. The line changes only in the cycle after a cycle in which `baud_tick` is high.
- R6: A byte is taken only in a cycle where `tx_valid` and `tx_ready` are both high. `tx_data`, `mp_bit_in`, `mp_mode_en` and `two_stop_sel` are captured then, and later changes to them do not alter the character.
- R7: With `cts_check_en` high, `cts_n` passes through two flip-flops. A pending character starts only from a tick cycle in which the synchronized pin reads 0, and its start bit appears in the next cycle. While the pin reads 1, the line stays high and `tx_busy` stays 1.
- R8: If `cts_n` rises while a character is being sent, every remaining bit, stop bits included, is still sent unchanged.
- R9: With `cts_check_en` low, `cts_n` has no effect on when or what is sent.
- R10: `tx_busy` rises in the cycle after acceptance. It stays high until the tick that ends the last stop bit, and it falls in the following cycle, together with `tx_ready` rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Engine idle and able to take a byte |
| mp_bit_in | input | 1 | Value of the ninth (address/data) bit |
| cts_check_en | input | 1 | Enables gating on the clear-to-send pin |
| mp_mode_en | input | 1 | Adds the ninth bit to the character |
| two_stop_sel | input | 1 | 0 selects one stop bit, 1 selects two |
| cts_n | input | 1 | Active-low clear-to-send pin, asynchronous |
| tx_line | output | 1 | Serial output, high when idle |
| tx_busy | output | 1 | A character is pending or being sent |

## Verification
All 256 byte values are sent. Each one also derives its ninth-bit enable, its ninth-bit value and its stop count from its own bits, so the sweep covers all four frame shapes. A fault in bit order, in the ninth-bit slot or in the stop count therefore shows up as a wrong level at a known cycle. Each test frame changes the inputs right after acceptance, which separates values captured at the handshake from values read live. Separate frames hold the pin deasserted before the start, raise it partway through a character, and raise it with checking switched off. These frames tell a correct gating decision apart from one that stalls too early, cuts a character short, or ignores the enable.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_WAIT = 2'd1,
      TX_SEND = 2'd2
   } tx_state_e;

   typedef struct packed {
      logic mp_en;
      logic two_stop;
      logic mp_val;
   } tx_cfg_t;

endpackage

// File: rtl/uart_tx_sync.sv
module uart_tx_sync #(
   parameter int  STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 0) begin : g_bad
         $error("uart_tx_sync: STAGES must not be negative");
      end

      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) chain[0] <= RESET_VAL;
                  else        chain[0] <= d;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) chain[s] <= RESET_VAL;
                  else        chain[s] <= chain[s-1];
               end
            end
         end
         assign q = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
   import uart_tx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 4
) (
   input  logic [IDX_W-1:0]  sel,
   input  logic [DATA_W-1:0] data,
   input  tx_cfg_t           cfg,
   output logic              bit_val,
   output logic [IDX_W-1:0]  last_idx
);

   localparam int MP_SLOT = DATA_W + 1;

   generate
      if ((1 << IDX_W) <= DATA_W + 3) begin : g_bad
         $error("uart_tx_frame: IDX_W too narrow for the frame");
      end
   endgenerate

   always_comb begin
      bit_val = 1'b1;
      if (sel == '0) begin
         bit_val = 1'b0;
      end else if (cfg.mp_en && sel == IDX_W'(MP_SLOT)) begin
         bit_val = cfg.mp_val;
      end else begin
         for (int k = 0; k < DATA_W; k++) begin
            if (sel == IDX_W'(k + 1)) bit_val = data[k];
         end
      end
   end

   assign last_idx = IDX_W'(DATA_W + 1) + IDX_W'(cfg.mp_en) + IDX_W'(cfg.two_stop);

endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
   import uart_tx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] data_in,
   input  tx_cfg_t           cfg_in,
   input  logic              cts_check_en,
   input  logic              cts_ok,
   input  logic              nxt_bit,
   input  logic [IDX_W-1:0]  last_idx,
   output logic [IDX_W-1:0]  idx_nxt,
   output logic [DATA_W-1:0] data_q,
   output tx_cfg_t           cfg_q,
   output logic              line,
   output logic              busy,
   output tx_state_e         state
);

   logic [IDX_W-1:0] idx;
   logic             go;

   assign idx_nxt  = idx + IDX_W'(1);
   assign go       = baud_tick && (!cts_check_en || cts_ok);
   assign in_ready = (state == TX_IDLE);
   assign busy     = (state != TX_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= TX_IDLE;
         idx    <= '0;
         data_q <= '0;
         cfg_q  <= '0;
         line   <= 1'b1;
      end else begin
         case (state)
            TX_IDLE: begin
               if (in_valid) begin
                  data_q <= data_in;
                  cfg_q  <= cfg_in;
                  state  <= TX_WAIT;
               end
            end
            TX_WAIT: begin
               if (go) begin
                  state <= TX_SEND;
                  idx   <= '0;
                  line  <= 1'b0;
               end
            end
            TX_SEND: begin
               if (baud_tick) begin
                  if (idx == last_idx) begin
                     state <= TX_IDLE;
                     line  <= 1'b1;
                  end else begin
                     idx  <= idx_nxt;
                     line <= nxt_bit;
                  end
               end
            end
            default: begin
               state <= TX_IDLE;
               line  <= 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/uart_tx_cts.sv
module uart_tx_cts
   import uart_tx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic              mp_bit_in,
   input  logic              cts_check_en,
   input  logic              mp_mode_en,
   input  logic              two_stop_sel,
   input  logic              cts_n,
   output logic              tx_line,
   output logic              tx_busy
);

   localparam int MAX_BITS = DATA_W + 4;
   localparam int IDX_W    = $clog2(MAX_BITS + 1);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("uart_tx_cts: DATA_W must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("uart_tx_cts: SYNC_STAGES must not be negative");
      end
   endgenerate

   logic              cts_n_s;
   logic              nxt_bit;
   logic [IDX_W-1:0]  last_idx;
   logic [IDX_W-1:0]  idx_nxt;
   logic [DATA_W-1:0] data_q;
   tx_cfg_t           cfg_in;
   tx_cfg_t           cfg_q;
   tx_state_e         state;
   logic              st_wait;

   assign cfg_in  = '{mp_en: mp_mode_en, two_stop: two_stop_sel, mp_val: mp_bit_in};
   assign st_wait = (state == TX_WAIT);

   uart_tx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cts_n),
      .q     (cts_n_s)
   );

   uart_tx_frame #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_frame (
      .sel      (idx_nxt),
      .data     (data_q),
      .cfg      (cfg_q),
      .bit_val  (nxt_bit),
      .last_idx (last_idx)
   );

   uart_tx_fsm #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .baud_tick    (baud_tick),
      .in_valid     (tx_valid),
      .in_ready     (tx_ready),
      .data_in      (tx_data),
      .cfg_in       (cfg_in),
      .cts_check_en (cts_check_en),
      .cts_ok       (!cts_n_s),
      .nxt_bit      (nxt_bit),
      .last_idx     (last_idx),
      .idx_nxt      (idx_nxt),
      .data_q       (data_q),
      .cfg_q        (cfg_q),
      .line         (tx_line),
      .busy         (tx_busy),
      .state        (state)
   );

endmodule

// File: rtl/uart_tx_cts_chk.sv
module uart_tx_cts_chk (
   input logic clk,
   input logic rst_n,
   input logic baud_tick,
   input logic tx_valid,
   input logic tx_ready,
   input logic cts_check_en,
   input logic cts_n,
   input logic tx_line,
   input logic tx_busy,
   input logic waiting
);

   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> tx_line);

   assert_tick_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_line != $past(tx_line)) |-> $past(baud_tick));

   assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> (tx_busy && !tx_ready));

   assert_cts_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && cts_check_en && $past(cts_n) && $past(cts_n, 2)) |=> (tx_line && tx_busy));

   assert_busy_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_busy) |-> ($past(baud_tick) && tx_ready));

endmodule

bind uart_tx_cts uart_tx_cts_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .baud_tick    (baud_tick),
   .tx_valid     (tx_valid),
   .tx_ready     (tx_ready),
   .cts_check_en (cts_check_en),
   .cts_n        (cts_n),
   .tx_line      (tx_line),
   .tx_busy      (tx_busy),
   .waiting      (st_wait)
);

// File: tb/sim_uart_tx_cts.sv
module sim_uart_tx_cts;

   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic [7:0] tx_data = '0;
   logic       tx_valid = 1'b0;
   logic       tx_ready;
   logic       mp_bit_in = 1'b0;
   logic       cts_check_en = 1'b0;
   logic       mp_mode_en = 1'b0;
   logic       two_stop_sel = 1'b0;
   logic       cts_n = 1'b0;
   logic       tx_line;
   logic       tx_busy;

   int  n_checks = 0;
   int  n_bad = 0;
   bit  done = 1'b0;
   int  tick_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      tick_cnt  <= (tick_cnt == TICK_DIV-1) ? 0 : tick_cnt + 1;
      baud_tick <= (tick_cnt == TICK_DIV-1);
   end

   uart_tx_cts u0 (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_data(tx_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .mp_bit_in(mp_bit_in),
      .cts_check_en(cts_check_en), .mp_mode_en(mp_mode_en),
      .two_stop_sel(two_stop_sel), .cts_n(cts_n), .tx_line(tx_line),
      .tx_busy(tx_busy)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Expected line level for bit i of a character.
   function automatic logic exp_bit(input int i, input logic [7:0] d,
                                    input logic mpv, input logic mpen);
      if (i == 0) return 1'b0;
      if (i <= 8) return d[i-1];
      if (i == 9 && mpen) return mpv;
      return 1'b1;
   endfunction

   function automatic string bit_req(input int i, input logic mpen);
      if (i <= 8) return "R2";
      if (i == 9 && mpen) return "R3";
      return "R4";
   endfunction

   // Sends one character and checks every cycle of it.
   // hold > 0: pin is deasserted for that many cycles before it is released (R7).
   // drop >= 0: pin rises during bit 'drop' (R8).
   task automatic run_frame(input logic [7:0] d, input logic mpv, input logic mpen,
                            input logic two, input int hold, input int drop);
      int  nbits;
      bit  seen;
      bit  ok;
      logic act;
      @(negedge clk);
      check(tx_ready == 1'b1 && tx_line == 1'b1, "R1", "idle before offer", {tx_ready, tx_line}, 2'b11);
      tx_data = d; mp_bit_in = mpv; mp_mode_en = mpen; two_stop_sel = two; tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      tx_data = ~d; mp_bit_in = ~mpv; mp_mode_en = ~mpen; two_stop_sel = ~two;  // R6: late changes ignored
      check(tx_busy == 1'b1 && tx_ready == 1'b0, "R10", "busy after accept", {tx_busy, tx_ready}, 2'b10);
      if (hold > 0) begin
         ok = 1'b1;
         for (int c = 0; c < hold; c++) begin
            if (tx_line !== 1'b1 || tx_busy !== 1'b1) ok = 1'b0;
            @(negedge clk);
         end
         check(ok, "R7", "held while pin deasserted", {31'd0, tx_line}, 32'd1);
         cts_n = 1'b0;
      end
      seen = 1'b0;
      for (int w = 0; w < 200 && !seen; w++) begin
         if (tx_line === 1'b0) seen = 1'b1;
         else @(negedge clk);
      end
      check(seen, "R7", "start bit appears", {31'd0, seen}, 32'd1);
      if (!seen) return;
      nbits = 10 + int'(mpen) + int'(two);
      for (int i = 0; i < nbits; i++) begin
         ok = 1'b1;
         act = exp_bit(i, d, mpv, mpen);
         for (int c = 0; c < TICK_DIV; c++) begin
            if (drop == i && c == 1) cts_n = 1'b1;
            if (tx_line !== exp_bit(i, d, mpv, mpen) || tx_busy !== 1'b1) begin
               ok = 1'b0;
               act = tx_line;
            end
            @(negedge clk);
         end
         check(ok, (drop >= 0 && i > drop) ? "R8" : bit_req(i, mpen), "bit level/duration R5",
               {31'd0, act}, {31'd0, exp_bit(i, d, mpv, mpen)});
      end
      check(tx_line == 1'b1 && tx_busy == 1'b0 && tx_ready == 1'b1, "R10", "end of character",
            {tx_line, tx_busy, tx_ready}, 3'b101);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(tx_line == 1'b1 && tx_busy == 1'b0 && tx_ready == 1'b1, "R1", "reset state",
            {tx_line, tx_busy, tx_ready}, 3'b101);

      // Sweep over every byte; frame options derived from the byte (R2 R3 R4 R6).
      for (int v = 0; v < 256; v++) begin
         logic [7:0] b;
         b = v[7:0];
         run_frame(b, b[2] ^ b[7], b[0], b[1], 0, -1);
      end

      // R9: checking off, pin deasserted, character goes out.
      cts_check_en = 1'b0; cts_n = 1'b1;
      run_frame(8'hA5, 1'b1, 1'b1, 1'b0, 0, -1);

      // R7: checking on, pin deasserted, start held off then released.
      cts_check_en = 1'b1; cts_n = 1'b1;
      run_frame(8'h3C, 1'b0, 1'b1, 1'b1, 40, -1);

      // R8: pin rises in the middle of a character.
      cts_n = 1'b0;
      run_frame(8'hC3, 1'b1, 1'b1, 1'b1, 0, 4);
      // Next character stays held while the pin is still up (R7).
      run_frame(8'h81, 1'b0, 1'b0, 1'b0, 24, -1);

      // R6: an offer while busy is not taken; after the character the line stays idle.
      cts_check_en = 1'b0; cts_n = 1'b0;
      fork
         run_frame(8'h5A, 1'b0, 1'b0, 1'b1, 0, -1);
         begin
            repeat (12) @(negedge clk);
            tx_valid = 1'b1;
            repeat (3) @(negedge clk);
            tx_valid = 1'b0;
         end
      join
      repeat (3 * TICK_DIV) @(negedge clk);
      check(tx_line == 1'b1 && tx_busy == 1'b0, "R6", "offer while busy ignored",
            {tx_line, tx_busy}, 2'b10);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_bad++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", n_checks, n_bad);
         $finish;
      end
   end

endmodule